// File: doc/BRIEF.md
# Byte-Stream Data Transfer Engine

This block carries the data phase of a memory-card transfer. Its two sides are a CPU-facing FIFO port and a byte-wide card data path. The CPU port is word-addressed and takes 1-, 2- or 4-byte accesses. The card path carries one byte per accepted valid/ready handshake in each direction.

A receive ring buffer collects bytes arriving from the card. A two-half transmit ring buffer holds bytes waiting to go out to the card. A remaining-byte counter, loaded from block length times block count, decides when the transfer ends.

Software sets the length and count, then pulses a start with a direction. It services the FIFO request flags and watches for the completion flags. The transmit side offers a partial-buffer command that switches to the other storage half and drops whatever was still queued. A clock-stop pulse aborts a running transfer at once.

Top module: `bse_engine`

## Requirements
- R1: After reset, the following are all 0: `busy`, `rx_req`, `tx_req`, `data_done`, `prog_done`, `blks_rem`, `card_tx_valid`, `card_rx_ready` and `cpu_rdata`.
- R2: A length write keeps only `cfg_wdata[11:0]`, and a count write keeps only `cfg_wdata[15:0]`. `blks_rem` always shows the stored count.
- R3: A start loads the remaining-byte counter with length × count. Exactly that many bytes cross the card interface before the engine goes idle. A product of zero ends the transfer without moving any byte.
- R4: In write direction (`xfer_dir_wr`=1), transmit bytes leave in push order whenever bytes remain and the buffer is not empty. `tx_req` is raised while bytes remain and the transmit buffer is empty. A CPU write clears `tx_req`.
- R5: In read direction, a card byte is accepted only while bytes remain and the receive buffer holds fewer than DEPTH (32) bytes. Every accepted byte sets `rx_req`, and a CPU read with no byte arriving in the same cycle clears it.
- R6: `cpu_size` selects the access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. On a CPU read of N bytes, the oldest byte goes to bits [8N-1:8N-8] and each following byte goes to the next lower lane. If the buffer empties early, the lanes left unfilled read 0, as do all bits above 8N.
- R7: On a CPU write of N bytes, the byte in bits [8N-1:8N-8] is queued first, followed by the lower lanes in order. Bytes that would take the transmit buffer beyond DEPTH are dropped.
- R8: When the counter reaches zero, `busy` falls and `data_done` sets in the same cycle. In write direction `prog_done` sets as well. Both flags clear at the next start.
- R9: A flush write with `cfg_wdata[0]`=1 discards every pending transmit byte and moves to the other storage half. A flush write with `cfg_wdata[0]`=0 has no effect.
- R10: A `clk_stop` pulse clears `busy` on the next edge. After that no card handshake is offered, and `data_done` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_we | input | 1 | Store block length from cfg_wdata |
| cfg_cnt_we | input | 1 | Store block count from cfg_wdata |
| cfg_flush_we | input | 1 | Partial-buffer command, acts when cfg_wdata[0]=1 |
| cfg_wdata | input | 32 | Configuration write data |
| xfer_start | input | 1 | Start a transfer |
| xfer_dir_wr | input | 1 | Direction at start: 1 = to card, 0 = from card |
| clk_stop | input | 1 | Abort the running transfer |
| cpu_rd | input | 1 | CPU read of the receive buffer |
| cpu_wr | input | 1 | CPU write to the transmit buffer |
| cpu_size | input | 2 | Access width code |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid while cpu_rd is high |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_valid | output | 1 | Byte to the card is offered |
| card_tx_ready | input | 1 | Card takes the byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Engine takes the byte |
| busy | output | 1 | Transfer in progress |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | Transfer completed |
| prog_done | output | 1 | Write transfer completed |
| blks_rem | output | 16 | Stored block count |

## Verification
Most faults in this block surface quickly on the card path. A wrong ring pointer or level corrupts the byte order in the very next handshake. A broken backpressure condition moves a byte past the buffer's capacity. A wrong counter load shows up as one byte too many or too few before `busy` falls, at the very end of the transfer. Lane-packing faults appear on `cpu_rdata` in the same cycle as the read. On the transmit side they appear only when the queued bytes are later drained, which is why a scoreboard compares every byte leaving the engine against the order the CPU wrote them.

// File: rtl/bse_pkg.sv
package bse_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

  // Number of byte lanes touched by an access of the given width code.
  function automatic logic [2:0] lane_count(input logic [1:0] sz);
    case (acc_size_e'(sz))
      ACC_BYTE: return 3'd1;
      ACC_HALF: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bse_rx_buf.sv
module bse_rx_buf #(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [7:0]                 push_data,
  input  logic                       pop_en,
  input  logic [2:0]                 pop_lanes,
  output logic [$clog2(DEPTH):0]     level,
  output logic [31:0]                rd_word
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] take;
  logic [AW-1:0] wr_idx;

  assign wr_idx = rd_ptr + level[AW-1:0];

  // Bytes actually popped: the request, limited by what is held.
  always_comb begin
    take = '0;
    if (pop_en) take = (LW'(pop_lanes) > level) ? level : LW'(pop_lanes);
  end

  // Oldest byte lands in the highest used lane.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < 4; i++) begin
      if (LW'(i) < take)
        rd_word[8*(int'(pop_lanes)-1-i) +: 8] = mem[rd_ptr + AW'(i)];
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      level <= '0;
    end else begin
      rd_ptr <= rd_ptr + take[AW-1:0];
      level  <= level + LW'(push) - take;
    end
  end

endmodule

// File: rtl/bse_tx_buf.sv
module bse_tx_buf #(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       flush,
  input  logic                       push_en,
  input  logic [2:0]                 push_lanes,
  input  logic [31:0]                push_word,
  input  logic                       pop,
  output logic [$clog2(DEPTH):0]     level,
  output logic [7:0]                 head
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [7:0]    mem [2*DEPTH];
  logic          bank;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] space;
  logic [LW-1:0] take;
  logic [AW-1:0] wr_base;

  assign space   = LW'(DEPTH) - level;
  assign wr_base = rd_ptr + level[AW-1:0];
  assign head    = mem[{bank, rd_ptr}];

  // Bytes accepted: the request, limited by free space; surplus is dropped.
  always_comb begin
    take = '0;
    if (push_en) take = (LW'(push_lanes) > space) ? space : LW'(push_lanes);
  end

  // Highest used lane is queued first.
  always_ff @(posedge clk) begin
    if (!clr && !flush) begin
      for (int i = 0; i < 4; i++) begin
        if (LW'(i) < take)
          mem[{bank, wr_base + AW'(i)}] <= push_word[8*(int'(push_lanes)-1-i) +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank   <= 1'b0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      bank  <= ~bank;
      level <= '0;
    end else if (clr) begin
      level <= '0;
    end else begin
      rd_ptr <= rd_ptr + AW'(pop);
      level  <= level + take - LW'(pop);
    end
  end

endmodule

// File: rtl/bse_ctrl.sv
module bse_ctrl #(
  parameter int REM_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_in,
  input  logic [REM_W-1:0] total,
  input  logic             abort,
  input  logic             byte_fire,
  input  logic             rx_fire,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic             tx_empty,
  output logic             busy,
  output logic             dir_wr,
  output logic             rem_nz,
  output logic             finish_evt,
  output logic             data_done,
  output logic             prog_done,
  output logic             rx_req,
  output logic             tx_req
);
  logic [REM_W-1:0] remaining;

  assign rem_nz     = (remaining != '0);
  assign finish_evt = busy && !abort &&
                      (!rem_nz || (byte_fire && remaining == REM_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dir_wr    <= 1'b0;
      remaining <= '0;
      data_done <= 1'b0;
      prog_done <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      dir_wr    <= dir_in;
      remaining <= total;
      data_done <= 1'b0;
      prog_done <= 1'b0;
    end else begin
      if (byte_fire) remaining <= remaining - REM_W'(1);
      if (finish_evt) begin
        busy      <= 1'b0;
        data_done <= 1'b1;
        if (dir_wr) prog_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (start && !abort)) rx_req <= 1'b0;
    else if (rx_fire)                rx_req <= 1'b1;
    else if (cpu_rd)                 rx_req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (start && !abort))                     tx_req <= 1'b0;
    else if (cpu_wr)                                     tx_req <= 1'b0;
    else if (busy && dir_wr && rem_nz && tx_empty)       tx_req <= 1'b1;
  end

endmodule

// File: rtl/bse_engine.sv
module bse_engine
  import bse_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_len_we,
  input  logic        cfg_cnt_we,
  input  logic        cfg_flush_we,
  input  logic [31:0] cfg_wdata,
  input  logic        xfer_start,
  input  logic        xfer_dir_wr,
  input  logic        clk_stop,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic [7:0]  card_tx_data,
  output logic        card_tx_valid,
  input  logic        card_tx_ready,
  input  logic [7:0]  card_rx_data,
  input  logic        card_rx_valid,
  output logic        card_rx_ready,
  output logic        busy,
  output logic        rx_req,
  output logic        tx_req,
  output logic        data_done,
  output logic        prog_done,
  output logic [15:0] blks_rem
);
  localparam int REM_W = LEN_W + CNT_W;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  function automatic logic [REM_W-1:0] total_bytes(input logic [LEN_W-1:0] l,
                                                   input logic [CNT_W-1:0] c);
    return REM_W'(l) * REM_W'(c);
  endfunction

  logic [LEN_W-1:0] blk_len;
  logic [CNT_W-1:0] blk_cnt;
  logic             unused_cfg_hi;
  logic [LVL_W-1:0] rx_level;
  logic [LVL_W-1:0] tx_level;
  logic [31:0]      rx_word;
  logic [2:0]       lanes;
  logic             dir_wr;
  logic             rem_nz;
  logic             finish_evt;
  logic             tx_fire;
  logic             rx_fire;
  logic             byte_fire;
  logic             flush_evt;
  logic             start_evt;

  assign unused_cfg_hi = ^cfg_wdata[31:CNT_W];
  assign lanes         = lane_count(cpu_size);
  assign flush_evt     = cfg_flush_we && cfg_wdata[0];
  assign start_evt     = xfer_start && !clk_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_len <= '0;
      blk_cnt <= '0;
    end else begin
      if (cfg_len_we) blk_len <= cfg_wdata[LEN_W-1:0];
      if (cfg_cnt_we) blk_cnt <= cfg_wdata[CNT_W-1:0];
    end
  end

  assign blks_rem = 16'(blk_cnt);

  // Card-side handshakes.
  assign card_tx_valid = busy && dir_wr && rem_nz && !clk_stop && (tx_level != '0);
  assign card_rx_ready = busy && !dir_wr && rem_nz && !clk_stop &&
                         (rx_level < LVL_W'(DEPTH));
  assign tx_fire       = card_tx_valid && card_tx_ready;
  assign rx_fire       = card_rx_valid && card_rx_ready;
  assign byte_fire     = tx_fire || rx_fire;

  assign cpu_rdata = cpu_rd ? rx_word : '0;

  bse_rx_buf #(.DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_evt),
    .push      (rx_fire),
    .push_data (card_rx_data),
    .pop_en    (cpu_rd),
    .pop_lanes (lanes),
    .level     (rx_level),
    .rd_word   (rx_word)
  );

  bse_tx_buf #(.DEPTH(DEPTH)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_evt),
    .flush      (flush_evt),
    .push_en    (cpu_wr),
    .push_lanes (lanes),
    .push_word  (cpu_wdata),
    .pop        (tx_fire),
    .level      (tx_level),
    .head       (card_tx_data)
  );

  bse_ctrl #(.REM_W(REM_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (xfer_start),
    .dir_in     (xfer_dir_wr),
    .total      (total_bytes(blk_len, blk_cnt)),
    .abort      (clk_stop),
    .byte_fire  (byte_fire),
    .rx_fire    (rx_fire),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .tx_empty   (tx_level == '0),
    .busy       (busy),
    .dir_wr     (dir_wr),
    .rem_nz     (rem_nz),
    .finish_evt (finish_evt),
    .data_done  (data_done),
    .prog_done  (prog_done),
    .rx_req     (rx_req),
    .tx_req     (tx_req)
  );

endmodule

// File: rtl/bse_engine_chk.sv
module bse_engine_chk #(
  parameter int DEPTH = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clk_stop,
  input logic                   xfer_start,
  input logic                   busy,
  input logic                   card_tx_valid,
  input logic                   card_rx_valid,
  input logic                   card_rx_ready,
  input logic                   cpu_wr,
  input logic                   rx_req,
  input logic                   tx_req,
  input logic                   data_done,
  input logic                   prog_done,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic [$clog2(DEPTH):0] tx_level
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(DEPTH)); // R5
  AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(DEPTH)); // R7
  AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && !clk_stop |=> busy); // R3
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> !busy); // R10
  AST_IDLE_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !card_tx_valid && !card_rx_ready); // R10
  AST_DONE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_done) |-> $fell(busy)); // R8
  AST_PROG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> data_done); // R8
  AST_RXREQ_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_valid && card_rx_ready && !xfer_start |=> rx_req); // R5
  AST_TXREQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !tx_req); // R4

endmodule

bind bse_engine bse_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk_stop      (clk_stop),
  .xfer_start    (xfer_start),
  .busy          (busy),
  .card_tx_valid (card_tx_valid),
  .card_rx_valid (card_rx_valid),
  .card_rx_ready (card_rx_ready),
  .cpu_wr        (cpu_wr),
  .rx_req        (rx_req),
  .tx_req        (tx_req),
  .data_done     (data_done),
  .prog_done     (prog_done),
  .rx_level      (rx_level),
  .tx_level      (tx_level)
);

// File: tb/tb_bse_engine.sv
`timescale 1ns/1ps
module tb_bse_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_len_we = 0, cfg_cnt_we = 0, cfg_flush_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_start = 0, xfer_dir_wr = 0, clk_stop = 0;
  logic        cpu_rd = 0, cpu_wr = 0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [7:0]  card_tx_data;
  logic        card_tx_valid;
  logic        card_tx_ready = 0;
  logic [7:0]  card_rx_data = '0;
  logic        card_rx_valid = 0;
  logic        card_rx_ready;
  logic        busy, rx_req, tx_req, data_done, prog_done;
  logic [15:0] blks_rem;

  int n_cmp = 0;
  int n_bad = 0;
  int mdl_tx_cnt = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] rx_src[$];
  logic [7:0] mdl_rx[$];

  always #4 clk = ~clk;

  bse_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_len_we(cfg_len_we), .cfg_cnt_we(cfg_cnt_we),
    .cfg_flush_we(cfg_flush_we), .cfg_wdata(cfg_wdata), .xfer_start(xfer_start),
    .xfer_dir_wr(xfer_dir_wr), .clk_stop(clk_stop), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .card_tx_data(card_tx_data), .card_tx_valid(card_tx_valid),
    .card_tx_ready(card_tx_ready), .card_rx_data(card_rx_data),
    .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready), .busy(busy),
    .rx_req(rx_req), .tx_req(tx_req), .data_done(data_done), .prog_done(prog_done),
    .blks_rem(blks_rem)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int nlanes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // Scoreboard monitor: every byte leaving toward the card is compared.
  always begin
    @(negedge clk); #2;
    if (card_tx_valid && card_tx_ready) begin
      if (exp_tx.size() == 0) check("R3 unexpected card byte", {24'h0, card_tx_data}, 32'hFFFF_FFFF);
      else check("R4 card byte order", {24'h0, card_tx_data}, {24'h0, exp_tx.pop_front()});
      mdl_tx_cnt--;
    end
  end

  // Card-side byte source for the read direction.
  always begin
    @(negedge clk);
    card_rx_valid = (rx_src.size() != 0);
    card_rx_data  = card_rx_valid ? rx_src[0] : 8'h00;
    #2;
    if (card_rx_valid && card_rx_ready) mdl_rx.push_back(rx_src.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic cfg(input int which, input logic [31:0] v);
    @(negedge clk);
    cfg_wdata = v;
    cfg_len_we = (which == 0); cfg_cnt_we = (which == 1); cfg_flush_we = (which == 2);
    if (which == 2 && v[0]) begin exp_tx.delete(); mdl_tx_cnt = 0; end
    @(negedge clk);
    cfg_len_we = 0; cfg_cnt_we = 0; cfg_flush_we = 0;
  endtask

  task automatic start(input logic dir);
    @(negedge clk);
    xfer_start = 1; xfer_dir_wr = dir;
    exp_tx.delete(); mdl_tx_cnt = 0; mdl_rx.delete();
    @(negedge clk);
    xfer_start = 0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] d);
    int n;
    @(negedge clk);
    n = nlanes(sz);
    cpu_wr = 1; cpu_size = sz; cpu_wdata = d;
    for (int i = 0; i < n; i++) begin
      if (mdl_tx_cnt < 32) begin
        exp_tx.push_back(d[8*(n-1-i) +: 8]);
        mdl_tx_cnt++;
      end
    end
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic rd(input logic [1:0] sz, output int got);
    int n;
    logic [31:0] e;
    @(negedge clk);
    cpu_rd = 1; cpu_size = sz;
    #1;
    n = nlanes(sz); e = '0; got = 0;
    for (int i = 0; i < n; i++) begin
      if (mdl_rx.size() != 0) begin
        e[8*(n-1-i) +: 8] = mdl_rx.pop_front();
        got++;
      end
    end
    check("R6 read packing", cpu_rdata, e);
    @(negedge clk);
    cpu_rd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
  endtask

  initial begin
    int got;
    int total;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 busy", {31'h0, busy}, 0);
    check("R1 flags", {27'h0, rx_req, tx_req, data_done, prog_done, card_tx_valid}, 0);
    check("R1 rx_ready", {31'h0, card_rx_ready}, 0);
    check("R1 blks_rem", {16'h0, blks_rem}, 0);
    check("R1 rdata", cpu_rdata, 0);

    // R2 masking and readback
    cfg(1, 32'hABCD_2345);
    #1 check("R2 blks_rem", {16'h0, blks_rem}, 32'h2345);

    // R3/R4/R8 write direction: length 0x7003 -> 3, count 2 -> 6 bytes
    cfg(0, 32'h0000_7003);
    cfg(1, 32'h0000_0002);
    card_tx_ready = 0;
    start(1'b1);
    repeat (2) @(negedge clk);
    #1 check("R4 tx_req raised when empty", {31'h0, tx_req}, 1);
    wr(2'd2, 32'h1122_3344);
    #1 check("R4 tx_req cleared by write", {31'h0, tx_req}, 0);
    wr(2'd1, 32'h0000_AABB);
    wr(2'd0, 32'h0000_00CC);
    wr(2'd0, 32'h0000_00DD);
    @(negedge clk); card_tx_ready = 1;
    wait_idle();
    repeat (2) @(negedge clk);
    #1;
    check("R3 leftover bytes after six sent", exp_tx.size(), 2);
    check("R3 no byte offered after count", {31'h0, card_tx_valid}, 0);
    check("R8 data_done write", {31'h0, data_done}, 1);
    check("R8 prog_done write", {31'h0, prog_done}, 1);
    exp_tx.delete();

    // R9 flush
    card_tx_ready = 0;
    cfg(0, 32'd4); cfg(1, 32'd1);
    start(1'b1);
    #1 check("R8 flags cleared by start", {30'h0, data_done, prog_done}, 0);
    wr(2'd2, 32'hDEAD_BEEF);
    cfg(2, 32'h0000_0000);
    #1 check("R9 flush bit0=0 keeps bytes", {31'h0, card_tx_valid}, 1);
    exp_tx.delete(); mdl_tx_cnt = 0;
    cfg(2, 32'h0000_0001);
    #1 check("R9 flush discards pending", {31'h0, card_tx_valid}, 0);
    wr(2'd2, 32'h0102_0304);
    @(negedge clk); card_tx_ready = 1;
    wait_idle();
    repeat (2) @(negedge clk);
    check("R9 new bytes all sent", exp_tx.size(), 0);

    // R7 overflow: 36 bytes offered to a 32-byte buffer
    card_tx_ready = 0;
    cfg(0, 32'd40); cfg(1, 32'd1);
    start(1'b1);
    for (int k = 0; k < 9; k++) wr(2'd2, {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)});
    check("R7 model kept 32", exp_tx.size(), 32);
    @(negedge clk); card_tx_ready = 1;
    repeat (40) @(negedge clk);
    check("R7 buffer drained", exp_tx.size(), 0);
    wr(2'd2, 32'hA0A1_A2A3);
    wr(2'd2, 32'hA4A5_A6A7);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R7 tail sent", exp_tx.size(), 0);
    #1 check("R8 done after 40", {31'h0, data_done}, 1);
    card_tx_ready = 0;

    // R5/R6 read direction with backpressure: 20 x 2 = 40 bytes
    cfg(0, 32'd20); cfg(1, 32'd2);
    start(1'b0);
    for (int k = 0; k < 40; k++) rx_src.push_back(8'(k + 8'h40));
    repeat (50) @(negedge clk);
    #1;
    check("R5 ready low when full", {31'h0, card_rx_ready}, 0);
    check("R5 rx_req set", {31'h0, rx_req}, 1);
    check("R5 held bytes", mdl_rx.size(), 32);
    total = 0;
    rd(2'd2, got); total += got;
    rd(2'd1, got); total += got;
    rd(2'd0, got); total += got;
    for (int k = 0; k < 200 && total < 40; k++) begin
      rd(2'd2, got); total += got;
    end
    repeat (3) @(negedge clk);
    #1;
    check("R5 all bytes read", total, 40);
    check("R5 rx_req cleared by read", {31'h0, rx_req}, 0);
    check("R8 read done", {30'h0, data_done, prog_done}, 32'h2);

    // R6 early stop
    cfg(0, 32'd2); cfg(1, 32'd1);
    start(1'b0);
    rx_src.push_back(8'hA1); rx_src.push_back(8'hA2);
    repeat (5) @(negedge clk);
    rd(2'd2, got);
    check("R6 short read count", got, 2);
    rd(2'd1, got);
    check("R6 empty read count", got, 0);

    // R10 abort
    cfg(0, 32'd100); cfg(1, 32'd1);
    start(1'b0);
    for (int k = 0; k < 5; k++) rx_src.push_back(8'(k));
    repeat (8) @(negedge clk);
    clk_stop = 1;
    @(negedge clk); clk_stop = 0;
    rx_src.push_back(8'h77);
    #1;
    check("R10 busy cleared", {31'h0, busy}, 0);
    check("R10 no done", {31'h0, data_done}, 0);
    repeat (3) @(negedge clk);
    #1 check("R10 no handshake", {31'h0, card_rx_ready}, 0);
    rx_src.delete();

    // R3 zero product
    cfg(1, 32'd0);
    start(1'b1);
    repeat (3) @(negedge clk);
    #1;
    check("R3 zero count idle", {31'h0, busy}, 0);
    check("R3 zero count done", {31'h0, data_done}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule